// File: doc/BRIEF.md
# Piecewise-Linear Power Function Unit

This unit approximates a smooth power or exponent curve, of the kind used in local response normalization, on single-precision floating-point operands. The curve is split into segments and each segment has a stored slope and intercept. For every input the unit picks a segment, reads that segment's coefficient pair, and computes `slope * x + intercept` in IEEE single precision. A new operand can enter on every clock, and each result appears a fixed number of cycles later.

The unit finds the segment without any range search. It concatenates an offset exponent with the leading `SHIFT_BIT` fraction bits of the input, so each binary octave holds `2^SHIFT_BIT` equal slices. Segments are therefore narrow near zero and grow wider as the magnitude rises. With `SHIFT_BIT = 2`, every segment spans a quarter of its octave, which is the setting meant to keep the approximation error within half a percent when suitable coefficients are loaded. Coefficients enter through a simple write port before operands are streamed.

Top module: `pwl_power_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `outValid` is low.
- R2: An operand sampled with `inValid` high at clock edge k gives `outValid` high after edge k+2, and only then (three-cycle latency). When `inValid` is low, no result appears three cycles later.
- R3: For an input whose biased exponent e lies in [EXP_MIN, EXP_MIN+EXP_SPAN-1] (defaults 119..134), the segment is `((e - EXP_MIN) << SHIFT_BIT) | fraction[22 -: SHIFT_BIT]`. With the defaults this gives 64 segments and a 6-bit index. The sign bit has no effect on the segment.
- R4: An input whose biased exponent is below EXP_MIN uses segment 0. This covers zero and subnormal inputs.
- R5: An input whose biased exponent is above the top of the range uses the last segment (63 by default).
- R6: When `cfgWe` is high at a clock edge, the segment at `cfgAddr` stores the slope from `cfgData[63:32]` and the intercept from `cfgData[31:0]`. An operand sampled at the next edge already sees the new pair.
- R7: The result is `slope * x` rounded to single precision, then added to the intercept and rounded again. Mixed signs subtract, and the sign of the result follows the larger magnitude.
- R8: The product rounds to nearest, with ties going to the even fraction.
- R9: The sum rounds to nearest, with ties going to the even fraction.
- R10: Subnormal operands count as zero, and results below the normal range become zero. The adder never produces a subnormal or a negative zero, so exact cancellation gives +0.
- R11: Operands presented on consecutive cycles give results on consecutive cycles, in the same order.
- R12: A product or sum whose exponent exceeds the finite range gives infinity with the correct sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Coefficient write strobe |
| cfgAddr | input | ADDR_W | Segment index being written |
| cfgData | input | 64 | Slope in the upper half, intercept in the lower half |
| inValid | input | 1 | Operand valid |
| inX | input | 32 | Single-precision operand |
| outValid | output | 1 | Result valid |
| outY | output | 32 | Single-precision result |

## Verification
The checks assume finite operands and coefficients. A NaN or infinity on the input is treated as an ordinary large number. The checks also assume the coefficient table is written before any segment is read, and never at the same address in the same cycle as a read. The stimulus meets these assumptions in three ways:
- It loads every segment before streaming any operands.
- It holds `cfgWe` low while operands are in flight.
- It uses only finite values for operands and coefficients.

Arithmetic cases use small integers, powers of two, and carefully chosen halfway products. This makes every expected result exact, or an exact tie, so it can be written by hand.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  localparam int FLT_W  = 32;
  localparam int WIDE_W = 51;

  typedef struct packed {
    logic [FLT_W-1:0] slope;
    logic [FLT_W-1:0] icpt;
  } coef_t;

  typedef struct packed {
    logic tblWrite;
    logic ld1;
    logic ld2;
    logic ld3;
  } strobe_t;

  function automatic logic [5:0] leadPos(input logic [WIDE_W-1:0] v);
    logic [5:0] pos;
    pos = '0;
    for (int i = 0; i < WIDE_W; i++) begin
      if (v[i]) pos = 6'(i);
    end
    return pos;
  endfunction

  function automatic logic roundUp(input logic lsb, input logic guard, input logic sticky);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/pwl_seg_index.sv
module pwl_seg_index #(
  parameter int SHIFT_BIT = 2,
  parameter int EXP_MIN   = 119,
  parameter int EXP_SPAN  = 16,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chkEn,
  input  logic [7:0]           expField,
  input  logic [SHIFT_BIT-1:0] topMan,
  output logic [ADDR_W-1:0]    segAddr
);
  localparam int         OFF_W  = ADDR_W - SHIFT_BIT;
  localparam logic [7:0] EXP_LO = 8'(EXP_MIN);
  localparam logic [7:0] EXP_HI = 8'(EXP_MIN + EXP_SPAN - 1);

  logic [OFF_W-1:0] expOff;
  logic             belowRange;
  logic             aboveRange;

  always_comb begin
    expOff     = OFF_W'(expField - EXP_LO);
    belowRange = expField < EXP_LO;
    aboveRange = expField > EXP_HI;
    if (belowRange)      segAddr = '0;
    else if (aboveRange) segAddr = '1;
    else                 segAddr = {expOff, topMan};
  end

  AST_SEG_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && expField < EXP_LO) |-> segAddr == '0); // R4
  AST_SEG_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && expField > EXP_HI) |-> segAddr == '1); // R5
  AST_SEG_FINE: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && expField >= EXP_LO && expField <= EXP_HI) |-> segAddr[SHIFT_BIT-1:0] == topMan); // R3

endmodule

// File: rtl/pwl_coef_table.sv
module pwl_coef_table
  import pwl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  coef_t             wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output coef_t             rdData
);
  coef_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

  AST_TABLE_STORE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> mem[$past(wrAddr)] == $past(wrData)); // R6

endmodule

// File: rtl/pwl_fmul.sv
module pwl_fmul (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkEn,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] res
);
  logic        sgn;
  logic        aZero;
  logic        bZero;
  logic        hiBit;
  logic        guard;
  logic        sticky;
  logic        rc;
  logic [47:0] prod;
  logic [22:0] man;
  logic [23:0] manR;
  logic [10:0] eTmp;

  always_comb begin
    aZero = opA[30:23] == 8'd0;
    bZero = opB[30:23] == 8'd0;
    sgn   = opA[31] ^ opB[31];
    prod  = 48'({1'b1, opA[22:0]}) * 48'({1'b1, opB[22:0]});
    hiBit = prod[47];
    if (hiBit) begin
      man    = prod[46:24];
      guard  = prod[23];
      sticky = |prod[22:0];
    end else begin
      man    = prod[45:23];
      guard  = prod[22];
      sticky = |prod[21:0];
    end
    rc   = pwl_pkg::roundUp(man[0], guard, sticky);
    manR = {1'b0, man} + {23'b0, rc};
    eTmp = {3'b0, opA[30:23]} + {3'b0, opB[30:23]} + {10'b0, hiBit} + {10'b0, manR[23]};
    if (aZero || bZero || eTmp <= 11'd127)
      res = {sgn, 31'b0};
    else if (eTmp >= 11'd382)
      res = {sgn, 8'hFF, 23'b0};
    else
      res = {sgn, 8'(eTmp - 11'd127), manR[22:0]};
  end

  AST_MUL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && (opA[30:23] == 8'd0 || opB[30:23] == 8'd0)) |-> res[30:0] == 31'd0); // R10
  AST_MUL_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && res[30:0] != 31'd0) |-> res[31] == (opA[31] ^ opB[31])); // R7

endmodule

// File: rtl/pwl_fadd.sv
module pwl_fadd
  import pwl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chkEn,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] res
);
  logic              aZero;
  logic              bZero;
  logic              swap;
  logic              isSub;
  logic              sgn;
  logic              guard;
  logic              sticky;
  logic              rc;
  logic [30:0]       keyA;
  logic [30:0]       keyB;
  logic [7:0]        eBig;
  logic [7:0]        eSml;
  logic [7:0]        dExp;
  logic [23:0]       mA;
  logic [23:0]       mB;
  logic [23:0]       mBig;
  logic [23:0]       mSml;
  logic [WIDE_W-1:0] wBig;
  logic [WIDE_W-1:0] wSml;
  logic [WIDE_W-1:0] sum;
  logic [WIDE_W-1:0] norm;
  logic [5:0]        lead;
  logic [5:0]        lz;
  logic [22:0]       man;
  logic [23:0]       manR;
  logic [9:0]        eTmp;

  always_comb begin
    aZero = opA[30:23] == 8'd0;
    bZero = opB[30:23] == 8'd0;
    keyA  = aZero ? 31'd0 : opA[30:0];
    keyB  = bZero ? 31'd0 : opB[30:0];
    mA    = aZero ? 24'd0 : {1'b1, opA[22:0]};
    mB    = bZero ? 24'd0 : {1'b1, opB[22:0]};
    swap  = keyB > keyA;
    eBig  = swap ? opB[30:23] : opA[30:23];
    eSml  = swap ? opA[30:23] : opB[30:23];
    mBig  = swap ? mB : mA;
    mSml  = swap ? mA : mB;
    sgn   = swap ? opB[31] : opA[31];
    isSub = opA[31] ^ opB[31];
    dExp  = eBig - eSml;
    wBig  = {1'b0, mBig, 26'b0};
    if (dExp > 8'd26) wSml = {50'b0, |mSml};
    else              wSml = {1'b0, mSml, 26'b0} >> dExp;
    sum    = isSub ? wBig - wSml : wBig + wSml;
    lead   = leadPos(sum);
    lz     = 6'd50 - lead;
    norm   = sum << lz;
    man    = norm[49:27];
    guard  = norm[26];
    sticky = |norm[25:0];
    rc     = roundUp(man[0], guard, sticky);
    manR   = {1'b0, man} + {23'b0, rc};
    eTmp   = {2'b0, eBig} + 10'd65 - {4'b0, lz} + {9'b0, manR[23]};
    if (sum == '0 || eTmp <= 10'd64)
      res = 32'd0;
    else if (eTmp >= 10'd319)
      res = {sgn, 8'hFF, 23'b0};
    else
      res = {sgn, 8'(eTmp - 10'd64), manR[22:0]};
  end

  AST_ADD_NORMALIZED: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && sum != '0) |-> norm[50]); // R7
  AST_ADD_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && res[30:23] == 8'd0) |-> (res[22:0] == 23'd0 && !res[31])); // R10
  AST_ADD_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (chkEn && opA[31] != opB[31] && opA[30:0] == opB[30:0]) |-> res == 32'd0); // R10

endmodule

// File: rtl/pwl_datapath.sv
module pwl_datapath
  import pwl_pkg::*;
#(
  parameter int SHIFT_BIT = 2,
  parameter int EXP_MIN   = 119,
  parameter int EXP_SPAN  = 16,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [63:0]       cfgData,
  input  logic [31:0]       inX,
  output logic [31:0]       outY
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] segAddr;
  coef_t             coef1;
  logic [31:0]       x1;
  logic [31:0]       mulOut;
  logic [31:0]       prod2;
  logic [31:0]       icpt2;
  logic [31:0]       addOut;
  logic [31:0]       sum3;

  pwl_seg_index #(
    .SHIFT_BIT(SHIFT_BIT), .EXP_MIN(EXP_MIN), .EXP_SPAN(EXP_SPAN), .ADDR_W(ADDR_W)
  ) u_index (
    .clk      (clk),
    .rstN     (rstN),
    .chkEn    (strobe.ld1),
    .expField (inX[30:23]),
    .topMan   (inX[22 -: SHIFT_BIT]),
    .segAddr  (segAddr)
  );

  pwl_coef_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_table (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.tblWrite),
    .wrAddr (cfgAddr),
    .wrData (coef_t'(cfgData)),
    .rdEn   (strobe.ld1),
    .rdAddr (segAddr),
    .rdData (coef1)
  );

  always_ff @(posedge clk) begin
    if (strobe.ld1) x1 <= inX;
  end

  pwl_fmul u_mul (
    .clk   (clk),
    .rstN  (rstN),
    .chkEn (strobe.ld2),
    .opA   (coef1.slope),
    .opB   (x1),
    .res   (mulOut)
  );

  always_ff @(posedge clk) begin
    if (strobe.ld2) begin
      prod2 <= mulOut;
      icpt2 <= coef1.icpt;
    end
  end

  pwl_fadd u_add (
    .clk   (clk),
    .rstN  (rstN),
    .chkEn (strobe.ld3),
    .opA   (prod2),
    .opB   (icpt2),
    .res   (addOut)
  );

  always_ff @(posedge clk) begin
    if (strobe.ld3) sum3 <= addOut;
  end

  assign outY = sum3;

endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWe,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.tblWrite = cfgWe;
    strobe.ld1      = inValid;
    strobe.ld2      = vPipe[0];
    strobe.ld3      = vPipe[1];
  end

  assign outValid = vPipe[STAGES-1];

  AST_LATENCY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid); // R2
  AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid); // R2

endmodule

// File: rtl/pwl_power_unit.sv
module pwl_power_unit
  import pwl_pkg::*;
#(
  parameter int SHIFT_BIT = 2,
  parameter int EXP_MIN   = 119,
  parameter int EXP_SPAN  = 16,
  parameter int ADDR_W    = $clog2(EXP_SPAN) + SHIFT_BIT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [63:0]       cfgData,
  input  logic              inValid,
  input  logic [31:0]       inX,
  output logic              outValid,
  output logic [31:0]       outY
);
  strobe_t strobe;

  pwl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pwl_datapath #(
    .SHIFT_BIT(SHIFT_BIT), .EXP_MIN(EXP_MIN), .EXP_SPAN(EXP_SPAN), .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .inX     (inX),
    .outY    (outY)
  );

endmodule

// File: tb/test_pwl_power_unit.sv
module test_pwl_power_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [63:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inX = '0;
  logic        outValid;
  logic [31:0] outY;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [31:0] ONE  = 32'h3F800000;
  localparam logic [31:0] TWO  = 32'h40000000;
  localparam logic [31:0] HALF = 32'h3F000000;

  always #10 clk = ~clk;

  pwl_power_unit i_pwl_power_unit (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inX(inX), .outValid(outValid), .outY(outY)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] segOf(input logic [31:0] x);
    if (x[30:23] < 8'd119) return 6'd0;
    if (x[30:23] > 8'd134) return 6'd63;
    return {4'(x[30:23] - 8'd119), x[22:21]};
  endfunction

  function automatic logic [31:0] tagOf(input logic [31:0] x);
    return ONE + {26'b0, segOf(x)};
  endfunction

  // Called at a negedge; writes at the next edge, returns at the following negedge.
  task automatic writeSeg(input int seg, input logic [31:0] slope, input logic [31:0] icpt);
    cfgWe = 1'b1; cfgAddr = 6'(seg); cfgData = {slope, icpt};
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Called at a negedge; operand sampled at next edge k, result expected after edge k+2.
  task automatic runOne(input string req, input logic [31:0] x, input logic [31:0] exp);
    inValid = 1'b1; inX = x;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({req, " R2 not yet valid"}, {31'b0, outValid}, 32'd0);
    @(negedge clk);
    check({req, " R2 valid"}, {31'b0, outValid}, 32'd1);
    check(req, outY, exp);
    @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 in reset", {31'b0, outValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, outValid}, 32'd0);
  endtask

  task automatic fillTable();
    for (int s = 0; s < 64; s++) writeSeg(s, 32'd0, ONE + 32'(s));
  endtask

  task automatic testSegments();
    runOne("R3 x=3.0",      32'h40400000, tagOf(32'h40400000));
    runOne("R3 x=3.5",      32'h40600000, tagOf(32'h40600000));
    runOne("R3 x=1.0",      32'h3F800000, tagOf(32'h3F800000));
    runOne("R3 x=1.25",     32'h3FA00000, tagOf(32'h3FA00000));
    runOne("R3 sign x=-3",  32'hC0400000, tagOf(32'h40400000));
    runOne("R3 low octave", 32'h3BE00000, 32'h3F800003);
    runOne("R3 top octave", 32'h43600000, 32'h3F80003F);
    runOne("R4 x=2^-20",    32'h35800000, ONE);
    runOne("R4 x=0",        32'h00000000, ONE);
    runOne("R4 subnormal",  32'h00000001, ONE);
    runOne("R5 x=2^24",     32'h4B800000, 32'h3F80003F);
    runOne("R5 x=2^127",    32'h7F000000, 32'h3F80003F);
  endtask

  task automatic testStream();
    logic [31:0] xs [8];
    xs = '{32'h40400000, 32'h3F800000, 32'h40600000, 32'h00000000,
           32'h4B800000, 32'h3FA00000, 32'h3C000000, 32'h42000000};
    @(negedge clk);
    for (int n = 0; n < 12; n++) begin
      if (n >= 3 && n < 11) begin
        check("R11 stream valid", {31'b0, outValid}, 32'd1);
        check("R11 stream order", outY, tagOf(xs[n-3]));
      end else begin
        check("R2 stream idle", {31'b0, outValid}, 32'd0);
      end
      if (n < 8) begin inValid = 1'b1; inX = xs[n]; end
      else       inValid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic testArith();
    writeSeg(38, TWO, ONE);
    runOne("R6 R7 2*3+1", 32'h40400000, 32'h40E00000);
    runOne("R7 2*(-3)+1", 32'hC0400000, 32'hC0A00000);
    writeSeg(38, ONE, 32'hBF800000);
    runOne("R6 R7 3-1", 32'h40400000, TWO);
    writeSeg(41, ONE, 32'hC0A00000);
    runOne("R10 cancel 5-5", 32'h40A00000, 32'h00000000);
    writeSeg(34, 32'h3F800001, 32'h00000000);
    runOne("R8 product tie", 32'h3FC00000, 32'h3FC00002);
    writeSeg(63, ONE, ONE);
    runOne("R9 sum tie down", 32'h4B800000, 32'h4B800000);
    writeSeg(63, ONE, 32'h40400000);
    runOne("R9 sum tie up", 32'h4B800000, 32'h4B800002);
    writeSeg(0, ONE, HALF);
    runOne("R4 R7 small x", 32'h35800000, 32'h3F000010);
    runOne("R10 subnormal x", 32'h00000001, HALF);
    writeSeg(40, 32'h7F000000, 32'h00000000);
    runOne("R12 overflow", 32'h40800000, 32'h7F800000);
  endtask

  initial begin
    testReset();
    fillTable();
    testSegments();
    testStream();
    testArith();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule